// File: doc/BRIEF.md
# Single-Accumulator Processor with Device Port

This block is a small processor built around one accumulator. It reads 16-bit instruction words from a word-addressed synchronous memory into an instruction register. It splits each word into a 4-bit opcode and a 12-bit operand field. It then carries out a load, store or add against memory, or a load or store against an external device. For memory opcodes the operand field is a memory word address. For device opcodes the same field selects one of 4096 devices. Data words are sign-magnitude numbers.

Every instruction starts with a fetch cycle, which reads the word at the program counter and steps the counter. The next cycle latches the word into the instruction register. An execute cycle follows. Memory loads and adds take one more write-back cycle, because read data arrives one cycle after the request. Any opcode outside the defined set stops the machine. It then stays stopped, with all strobes low, until reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, the state is forced to fetch, the program counter to 0 and the accumulator to 0. In the cycle after any clock edge at which `rst` was high, the block drives `mem_rd` high with `mem_addr` = 0 and `halted` low.
- R2: Instruction words use bits 15:12 as the opcode and bits 11:0 as the operand field. Instructions are fetched from consecutive addresses, starting at 0, with the program counter advancing by one per instruction.
- R3: Opcode 0x1 copies the memory word at the operand address into the accumulator.
- R4: Opcode 0x2 writes the accumulator to the memory word at the operand address (`mem_wr` high, `mem_wdata` = accumulator).
- R5: Opcode 0x5 adds the memory word at the operand address to the accumulator in sign-magnitude form: bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude. For operands of unlike sign, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger.
- R6: A sum whose magnitude is zero always has sign bit 0. For like-signed operands, the carry out of the 15-bit magnitude is dropped (the magnitude wraps modulo 2^15).
- R7: Opcode 0x3 raises `io_rd` for one cycle with `io_dev` = operand field. The accumulator takes the value on `io_rdata` in that same cycle.
- R8: Opcode 0x7 raises `io_wr` for one cycle with `io_dev` = operand field and `io_wdata` = accumulator.
- R9: Any other opcode (0x0, 0x4, 0x6, 0x8 to 0xF) sets `halted`. `halted` then stays high and no strobe is raised until reset, so no later instruction takes effect.
- R10: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is high in any cycle.
- R11: Memory read data is taken from `mem_rdata` in the cycle after `mem_rd` is raised. A program that loads word 0x940 (holding 3), adds word 0x941 (holding 2) and stores to 0x941 leaves 5 in 0x941.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address (program counter on fetch, operand field on execute) |
| mem_rd | output | 1 | Memory read request; data is returned on the following cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| io_dev | output | 12 | Selected device number |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| io_wdata | output | 16 | Device write data (accumulator) |
| io_rdata | input | 16 | Device read data, sampled in the `io_rd` cycle |
| halted | output | 1 | High once an undefined opcode has been executed |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `io_rdata` is a stable function of `io_dev` during the cycle in which `io_rd` is high. The bench meets both assumptions: it holds reset from time zero, and it derives `io_rdata` combinationally from `io_dev` through a fixed mixing function. The bench's memory model returns read data exactly one cycle after a request, which matches the latency the design expects. Random programs place their data in a separate address range so that stores never overwrite instructions, and every random program ends in an undefined opcode so that each run stops.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_LATCH,
      ST_EXEC,
      ST_WB,
      ST_HALT
   } state_t;

   typedef struct packed {
      logic ld_mem;
      logic st_mem;
      logic add_mem;
      logic ld_io;
      logic st_io;
      logic bad;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_dec.sv
module acc_cpu_dec #(
   parameter int OP_W = 4,
   parameter logic [OP_W-1:0] OPC_LD_MEM  = OP_W'(1),
   parameter logic [OP_W-1:0] OPC_ST_MEM  = OP_W'(2),
   parameter logic [OP_W-1:0] OPC_LD_IO   = OP_W'(3),
   parameter logic [OP_W-1:0] OPC_ADD_MEM = OP_W'(5),
   parameter logic [OP_W-1:0] OPC_ST_IO   = OP_W'(7)
) (
   input  logic [OP_W-1:0]     opcode,
   output acc_cpu_pkg::ctl_t   ctl
);

   always_comb begin
      ctl = '0;
      unique case (opcode)
         OPC_LD_MEM:  ctl.ld_mem  = 1'b1;
         OPC_ST_MEM:  ctl.st_mem  = 1'b1;
         OPC_ADD_MEM: ctl.add_mem = 1'b1;
         OPC_LD_IO:   ctl.ld_io   = 1'b1;
         OPC_ST_IO:   ctl.st_io   = 1'b1;
         default:     ctl.bad     = 1'b1;
      endcase
   end

endmodule

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum
);

   localparam int MAG_W = DATA_W - 1;

   logic             sa, sb, a_ge, same, sgn;
   logic [MAG_W-1:0] ma, mb, mag_sum, mag_dif, mag;

   always_comb begin
      sa      = a[DATA_W-1];
      sb      = b[DATA_W-1];
      ma      = a[MAG_W-1:0];
      mb      = b[MAG_W-1:0];
      same    = (sa == sb);
      a_ge    = (ma >= mb);
      mag_sum = ma + mb;
      mag_dif = a_ge ? (ma - mb) : (mb - ma);
      mag     = same ? mag_sum : mag_dif;
      sgn     = same ? sa : (a_ge ? sa : sb);
      // a zero magnitude is always reported as positive
      sum     = {sgn & (mag != '0), mag};
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu #(
   parameter int DATA_W = 16,
   parameter int OP_W   = 4,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] io_dev,
   output logic              io_rd,
   output logic              io_wr,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic              halted
);
   import acc_cpu_pkg::*;

   localparam int OPC_LSB = DATA_W - OP_W;

   generate
      if (OP_W + ADDR_W != DATA_W) begin : g_bad_split
         $error("acc_cpu: opcode and operand widths must fill the word");
      end
      if (OP_W < 3) begin : g_bad_op
         $error("acc_cpu: opcode field too narrow for the opcode set");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("acc_cpu: word needs a sign and a magnitude");
      end
   endgenerate

   state_t            st_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] acc_q;
   logic [OP_W-1:0]   opc;
   logic [ADDR_W-1:0] fld;
   ctl_t              ctl;
   logic [DATA_W-1:0] sum;
   logic              in_exec;

   assign opc     = ir_q[DATA_W-1:OPC_LSB];
   assign fld     = ir_q[ADDR_W-1:0];
   assign in_exec = (st_q == ST_EXEC);

   acc_cpu_dec #(.OP_W(OP_W)) u_dec (
      .opcode (opc),
      .ctl    (ctl)
   );

   acc_cpu_smadd #(.DATA_W(DATA_W)) u_add (
      .a   (acc_q),
      .b   (mem_rdata),
      .sum (sum)
   );

   always_comb begin
      mem_rd    = (st_q == ST_FETCH) || (in_exec && (ctl.ld_mem || ctl.add_mem));
      mem_wr    = in_exec && ctl.st_mem;
      mem_addr  = (st_q == ST_FETCH) ? pc_q : fld;
      mem_wdata = acc_q;
      io_dev    = fld;
      io_rd     = in_exec && ctl.ld_io;
      io_wr     = in_exec && ctl.st_io;
      io_wdata  = acc_q;
      halted    = (st_q == ST_HALT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_FETCH;
         pc_q  <= '0;
         ir_q  <= '0;
         acc_q <= '0;
      end else begin
         unique case (st_q)
            ST_FETCH: begin
               pc_q <= pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
               st_q <= ST_LATCH;
            end
            ST_LATCH: begin
               ir_q <= mem_rdata;
               st_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (ctl.bad) begin
                  st_q <= ST_HALT;
               end else if (ctl.ld_io) begin
                  acc_q <= io_rdata;
                  st_q  <= ST_FETCH;
               end else if (ctl.ld_mem || ctl.add_mem) begin
                  st_q <= ST_WB;
               end else begin
                  st_q <= ST_FETCH;
               end
            end
            ST_WB: begin
               acc_q <= ctl.ld_mem ? mem_rdata : sum;
               st_q  <= ST_FETCH;
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_rdata,
   input logic [DATA_W-1:0] acc,
   input logic              halted
);

   // R1
   rst_fetch_chk: assert property (@(posedge clk)
      rst |=> (mem_rd && mem_addr == '0 && !halted));

   // R10
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      halted |-> !(mem_rd || mem_wr || io_rd || io_wr));

   // R7
   io_load_chk: assert property (@(posedge clk) disable iff (rst)
      io_rd |=> (acc == $past(io_rdata)));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_rdata (io_rdata),
   .acc      (acc_q),
   .halted   (halted)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr, io_dev;
   logic        mem_rd, mem_wr, io_rd, io_wr, halted;
   logic [15:0] mem_wdata, io_wdata, io_rdata;
   logic [15:0] mem_rdata = '0;

   logic [15:0] mem     [0:4095];
   logic [15:0] exp_mem [0:4095];
   logic [11:0] log_dev [0:255];
   logic [15:0] log_dat [0:255];
   logic [11:0] xlog_dev [0:63];
   logic [15:0] xlog_dat [0:63];
   int          io_n = 0;
   int          xio_n;
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   int          multi_viol = 0;
   int          halt_viol = 0;

   always #4 clk = ~clk;

   acc_cpu dut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_dev(io_dev), .io_rd(io_rd),
      .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .halted(halted)
   );

   function automatic logic [15:0] io_fn(input logic [11:0] d);
      return {d[3:0], ~d[11:4], d[3:0]} ^ 16'h5A3C;
   endfunction

   assign io_rdata = io_fn(io_dev);

   function automatic logic [15:0] sm_add(input logic [15:0] a, input logic [15:0] b);
      int va, vb, s, m;
      logic sg;
      va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
      vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
      s  = va + vb;
      sg = (s < 0);
      m  = sg ? -s : s;
      if (m > 32767) m = m - 32768;
      if (m == 0) sg = 1'b0;
      return {sg, 15'(m)};
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (io_wr && io_n < 256) begin
         log_dev[io_n] <= io_dev;
         log_dat[io_n] <= io_wdata;
         io_n <= io_n + 1;
      end
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired act %0d exp %0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         if ($countones({mem_rd, mem_wr, io_rd, io_wr}) > 1) multi_viol++;
         if (halted && (mem_rd || mem_wr || io_rd || io_wr)) halt_viol++;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act %h exp %h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [15:0] v);
      mem[a]     = v;
      exp_mem[a] = v;
   endtask

   task automatic ref_run();
      int          pc;
      logic [15:0] acc, ir;
      logic [11:0] f;
      pc    = 0;
      acc   = '0;
      xio_n = 0;
      for (int step = 0; step < 5000; step++) begin
         ir = exp_mem[pc];
         pc = (pc + 1) % 4096;
         f  = ir[11:0];
         case (ir[15:12])
            4'h1: acc = exp_mem[f];
            4'h2: exp_mem[f] = acc;
            4'h5: acc = sm_add(acc, exp_mem[f]);
            4'h3: acc = io_fn(f);
            4'h7: begin
               if (xio_n < 64) begin
                  xlog_dev[xio_n] = f;
                  xlog_dat[xio_n] = acc;
               end
               xio_n++;
            end
            default: break;
         endcase
      end
   endtask

   // reset, then run until halted; returns index of first logged device write
   task automatic run_dut(output int base);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      base = io_n;
      rst = 1'b0;
      for (int w = 0; w < 2000 && !halted; w++) @(negedge clk);
      chk(halted, "R9 program reached halt", {31'b0, halted}, 32'd1);
   endtask

   task automatic cmp_io(input int base, input string req);
      chk(io_n - base == xio_n, req, io_n - base, xio_n);
      for (int k = 0; k < xio_n && k < 64; k++) begin
         chk(log_dev[base+k] == xlog_dev[k], req, {20'b0, log_dev[base+k]}, {20'b0, xlog_dev[k]});
         chk(log_dat[base+k] == xlog_dat[k], req, {16'b0, log_dat[base+k]}, {16'b0, xlog_dat[k]});
      end
   endtask

   function automatic logic [3:0] bad_op();
      logic [3:0] o;
      do o = 4'($urandom_range(0, 15));
      while (o == 4'h1 || o == 4'h2 || o == 4'h3 || o == 4'h5 || o == 4'h7);
      return o;
   endfunction

   initial begin
      int base, sd, hv;
      logic [15:0] pa [0:5];
      logic [15:0] pb [0:5];
      sd = $urandom(32'd20711);
      for (int i = 0; i < 4096; i++) put(i, 16'h0000);

      // R1: reset state and first fetch
      repeat (3) @(negedge clk);
      chk(!halted, "R1 halted low in reset", {31'b0, halted}, 32'd0);
      rst = 1'b0;
      #1;
      chk(mem_rd && mem_addr == 12'h000, "R1 first fetch at address 0",
          {19'b0, mem_rd, mem_addr}, {19'b0, 1'b1, 12'h000});
      @(negedge clk);

      // R11 R3 R5 R4: sample program 3 + 2 -> 5
      put(0, 16'h1940); put(1, 16'h5941); put(2, 16'h2941); put(3, 16'h0000);
      put(12'h940, 16'd3); put(12'h941, 16'd2);
      run_dut(base);
      chk(mem[12'h941] == 16'd5, "R11 sample program sum", {16'b0, mem[12'h941]}, 32'd5);
      chk(mem[12'h940] == 16'd3, "R3 operand left intact", {16'b0, mem[12'h940]}, 32'd3);

      // R5 R6: sign-magnitude corner cases
      pa[0] = 16'h0005; pb[0] = 16'h8005;
      pa[1] = 16'h8003; pb[1] = 16'h8004;
      pa[2] = 16'h7FFF; pb[2] = 16'h0001;
      pa[3] = 16'hFFFF; pb[3] = 16'h8001;
      pa[4] = 16'h0003; pb[4] = 16'h800A;
      pa[5] = 16'h8000; pb[5] = 16'h8000;
      for (int k = 0; k < 6; k++) begin
         put(12'hA00 + 2*k, pa[k]); put(12'hA01 + 2*k, pb[k]);
         put(3*k,     {4'h1, 12'hA00 + 12'(2*k)});
         put(3*k + 1, {4'h5, 12'hA01 + 12'(2*k)});
         put(3*k + 2, {4'h2, 12'h900 + 12'(k)});
      end
      put(18, 16'hF000);
      run_dut(base);
      for (int k = 0; k < 6; k++)
         chk(mem[12'h900 + k] == sm_add(pa[k], pb[k]), (k == 0 || k >= 2) ?
             "R6 zero sign or magnitude wrap" : "R5 sign-magnitude add",
             {16'b0, mem[12'h900 + k]}, {16'b0, sm_add(pa[k], pb[k])});
      chk(mem[12'h902] == 16'h0000, "R6 overflow wraps to +0", {16'b0, mem[12'h902]}, 32'h0);
      chk(mem[12'h904] == 16'h8007, "R5 unlike signs take larger sign", {16'b0, mem[12'h904]}, 32'h8007);

      // R7 R8: device load and store
      put(0, 16'h3ABC); put(1, 16'h7123); put(2, 16'h2D00); put(3, 16'h1D01);
      put(4, 16'h7FFF); put(5, 16'h0000); put(12'hD01, 16'h8421);
      run_dut(base);
      chk(io_n - base == 2, "R8 device write count", io_n - base, 32'd2);
      chk(log_dev[base] == 12'h123, "R8 device number", {20'b0, log_dev[base]}, 32'h123);
      chk(log_dat[base] == io_fn(12'hABC), "R7 device read into accumulator",
          {16'b0, log_dat[base]}, {16'b0, io_fn(12'hABC)});
      chk(mem[12'hD00] == io_fn(12'hABC), "R7 device value stored", {16'b0, mem[12'hD00]},
          {16'b0, io_fn(12'hABC)});
      chk(log_dev[base+1] == 12'hFFF && log_dat[base+1] == 16'h8421, "R8 second device write",
          {4'b0, log_dev[base+1], log_dat[base+1]}, {4'b0, 12'hFFF, 16'h8421});

      // R9: undefined opcode stops later instructions
      put(0, 16'h1E00); put(1, 16'h9000); put(2, 16'h2E01); put(3, 16'h7055);
      put(12'hE00, 16'h1234); put(12'hE01, 16'hBEEF);
      run_dut(base);
      hv = halt_viol;
      repeat (20) @(negedge clk);
      chk(mem[12'hE01] == 16'hBEEF, "R9 store after halt ignored", {16'b0, mem[12'hE01]}, 32'hBEEF);
      chk(io_n == base, "R9 device write after halt ignored", io_n, base);
      chk(halted, "R9 halt stays set", {31'b0, halted}, 32'd1);
      chk(halt_viol == hv && halt_viol == 0, "R9 no strobes while halted", halt_viol, 32'd0);

      // R2 R3 R4 R5 R7 R8: random straight-line programs
      for (int p = 0; p < 20; p++) begin
         int n;
         n = 10 + $urandom_range(0, 30);
         for (int a = 0; a < 16; a++) begin
            logic [15:0] v;
            v = 16'($urandom);
            if (a[1:0] == 2'b00) v[14:0] = 15'($urandom_range(0, 3));
            if (a == 5) v = {$urandom_range(0, 1) == 1, 15'h7FFF};
            put(12'hC00 + a, v);
         end
         for (int i = 0; i < n; i++) begin
            logic [3:0] op;
            logic [11:0] f;
            case ($urandom_range(0, 4))
               0: op = 4'h1;
               1: op = 4'h2;
               2: op = 4'h5;
               3: op = 4'h3;
               default: op = 4'h7;
            endcase
            f = (op == 4'h3 || op == 4'h7) ? 12'($urandom) : 12'hC00 + 12'($urandom_range(0, 15));
            put(i, {op, f});
         end
         put(n, {bad_op(), 12'($urandom)});
         ref_run();
         run_dut(base);
         for (int a = 0; a < 16; a++)
            chk(mem[12'hC00 + a] == exp_mem[12'hC00 + a], "R2 R3 R4 R5 random memory image",
                {16'b0, mem[12'hC00 + a]}, {16'b0, exp_mem[12'hC00 + a]});
         cmp_io(base, "R7 R8 random device log");
      end

      chk(multi_viol == 0, "R10 one strobe per cycle", multi_viol, 32'd0);
      chk(halt_viol == 0, "R9 quiet when halted", halt_viol, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule